// File: doc/BRIEF.md
# Saturating Wiper Adjust Command Unit

This block keeps a bank of N wiper position registers, each W bits wide, and changes them when a decoded command is executed. One execute strobe is given per chip-select rising edge. Each command that changes a wiper acts on one addressed channel or on every channel. It can do one of four things: load a new value, step the value by one, or shift it by one bit toward all-ones or all-zeros, which is a 6 dB step. Every step and shift stops at the end of the range and never wraps.

The unit remembers the last adjust command it was given. A strobe that comes without a new command word runs that command again, so a push button tied to chip select can move a wiper one notch per press. An active-low write-protect input blocks every change that a strobe would make. The load ports from the nonvolatile controller still apply while write protect is low, because they carry restores from the stored values. Serial framing and nonvolatile timing are handled outside this block.

Top module: `wiper_adjust`

## Requirements
- R1: After reset every wiper reads midscale (only the top bit set, 0x20 for W=6) and no command is remembered for repeating.
- R2: A fresh strobe with code 11 writes the low W bits of the data byte into the wiper selected by the address. Other wipers keep their values.
- R3: Code 14 adds one to the addressed wiper and holds it at all-ones. Code 6 subtracts one and holds it at zero.
- R4: Code 15 adds one to every wiper and code 7 subtracts one from every wiper. Each wiper saturates on its own.
- R5: Code 12 shifts the addressed wiper left one bit with a 1 entering the LSB. Code 4 shifts it right one bit with a 0 entering the MSB.
- R6: Code 13 applies the left shift of R5 to every wiper. Code 5 applies the right shift to every wiper.
- R7: Codes 4 through 7 and 12 through 15 (command bit 2 set) ignore the data byte.
- R8: A strobe with the fresh flag low repeats the most recent fresh command if that command had bit 2 set. If the most recent fresh command was any other code, the strobe changes nothing.
- R9: While the write-protect input is low, no strobe changes any wiper, but the nonvolatile load ports still take effect.
- R10: A load port bit set in a cycle copies the matching slice of the load value into that wiper on the next edge. This wins over a command to the same wiper in the same cycle.
- R11: Addressed commands whose address is N or above change no wiper.
- R12: Codes 0 to 3 and 8 to 10 change no wiper when strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle execute pulse, one per chip-select rise |
| fresh | input | 1 | A new command word comes with this strobe |
| cmd | input | 4 | Command code |
| addr | input | 4 | Channel address |
| data | input | 8 | Data byte, low W bits used |
| wp_n | input | 1 | Write protect, active low |
| nv_load | input | N | Per-channel restore enable from the nonvolatile controller |
| nv_val | input | N*W | Restore values, channel i at bits i*W+W-1 : i*W |
| wiper | output | N*W | Wiper values, channel i at bits i*W+W-1 : i*W |

## Verification
Every result is due one cycle after its stimulus. Commands, repeats and restores all write the wiper registers on the clock edge that samples the strobe or the load bit, and no other stage lies in between. The driver applies inputs at a falling edge and takes them away at the next falling edge. It then queues the expected wiper vector, and the monitor compares that vector against the outputs at a later falling edge. Between operations the driver leaves one quiet cycle, so each comparison sees the state after exactly one operation.

// File: rtl/wiper_adjust.sv
module wiper_adjust #(
  parameter int N = 4,
  parameter int W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic           fresh,
  input  logic [3:0]     cmd,
  input  logic [3:0]     addr,
  input  logic [7:0]     data,
  input  logic           wp_n,
  input  logic [N-1:0]   nv_load,
  input  logic [N*W-1:0] nv_val,
  output logic [N*W-1:0] wiper
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ZERO = '0;

  logic       rep_v;
  logic [3:0] rep_cmd, rep_addr;
  logic [3:0] ecmd, eaddr;
  logic       is_adj, is_wr, go;

  assign ecmd   = fresh ? cmd : (rep_v ? rep_cmd : 4'd0);
  assign eaddr  = fresh ? addr : rep_addr;
  assign is_adj = ecmd[2];
  assign is_wr  = (ecmd == 4'd11);
  assign go     = strobe && wp_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_v    <= 1'b0;
      rep_cmd  <= 4'd0;
      rep_addr <= 4'd0;
    end else if (strobe && fresh) begin
      rep_v    <= cmd[2];
      rep_cmd  <= cmd;
      rep_addr <= addr;
    end
  end

  generate
    if (W < 8) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^data[7:W];
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_ch
      localparam logic [3:0] IDX = 4'(i);
      logic [W-1:0] q, nxt;
      logic         hit, sel;

      assign hit = (eaddr == IDX);
      assign sel = go && (is_wr ? hit : (is_adj && (ecmd[0] || hit)));

      always_comb begin
        if (is_wr) nxt = data[W-1:0];
        else begin
          case ({ecmd[3], ecmd[1]})
            2'b11:   nxt = (q == ONES) ? q : q + 1'b1;
            2'b01:   nxt = (q == ZERO) ? q : q - 1'b1;
            2'b10:   nxt = {q[W-2:0], 1'b1};
            default: nxt = {1'b0, q[W-1:1]};
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n)          q <= MID;
        else if (nv_load[i]) q <= nv_val[i*W +: W];
        else if (sel)        q <= nxt;
      end

      assign wiper[i*W +: W] = q;
    end
  endgenerate
endmodule

// File: rtl/wiper_adjust_chk.sv
module wiper_adjust_chk #(
  parameter int N = 4,
  parameter int W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           strobe,
  input logic           fresh,
  input logic [3:0]     cmd,
  input logic [3:0]     addr,
  input logic           wp_n,
  input logic [N-1:0]   nv_load,
  input logic [N*W-1:0] nv_val,
  input logic [N*W-1:0] wiper
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};

  p_mid_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wiper == {N{MID}}));

  p_protect_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && nv_load == '0) |=> $stable(wiper));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && nv_load == '0) |=> $stable(wiper));

  p_inc_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && fresh && wp_n && cmd == 4'd14 && addr == 4'd0 && !nv_load[0] &&
     wiper[W-1:0] == ONES) |=> (wiper[W-1:0] == ONES));

  p_dec_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && fresh && wp_n && cmd == 4'd6 && addr == 4'd0 && !nv_load[0] &&
     wiper[W-1:0] == '0) |=> (wiper[W-1:0] == '0));

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_ld
      p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nv_load[i] |=> (wiper[i*W +: W] == $past(nv_val[i*W +: W])));
    end
  endgenerate
endmodule

bind wiper_adjust wiper_adjust_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .fresh(fresh), .cmd(cmd),
  .addr(addr), .wp_n(wp_n), .nv_load(nv_load), .nv_val(nv_val), .wiper(wiper)
);

// File: tb/wiper_adjust_test.sv
module wiper_adjust_test;
  localparam int N = 4;
  localparam int W = 6;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic           clk = 0;
  logic           rst_n = 0;
  logic           strobe = 0, fresh = 0, wp_n = 1;
  logic [3:0]     cmd = 0, addr = 0;
  logic [7:0]     data = 0;
  logic [N-1:0]   nv_load = 0;
  logic [N*W-1:0] nv_val = 0;
  logic [N*W-1:0] wiper;

  wiper_adjust #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fresh(fresh), .cmd(cmd),
    .addr(addr), .data(data), .wp_n(wp_n), .nv_load(nv_load), .nv_val(nv_val),
    .wiper(wiper)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [N*W-1:0] exp;
    string          tag;
  } item_t;

  item_t          q[$];
  int             checks = 0, errors = 0;
  logic [W-1:0]   m [N];
  logic           m_rv = 0;
  logic [3:0]     m_rc = 0, m_ra = 0;
  bit             done = 0;

  function automatic logic [N*W-1:0] pack();
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = m[k];
    return v;
  endfunction

  function automatic logic [W-1:0] step(input logic [3:0] c, input logic [W-1:0] x);
    case (c)
      4'd14, 4'd15: return (x == ONES) ? x : x + 1'b1;
      4'd6,  4'd7:  return (x == 0) ? x : x - 1'b1;
      4'd12, 4'd13: return {x[W-2:0], 1'b1};
      default:      return {1'b0, x[W-1:1]};
    endcase
  endfunction

  task automatic model(input logic s, input logic f, input logic [3:0] c,
                       input logic [3:0] a, input logic [7:0] d, input logic wp,
                       input logic [N-1:0] ld, input logic [N*W-1:0] lv);
    logic [3:0] ec, ea;
    ec = 4'd0; ea = 4'd0;
    if (s) begin
      if (f) begin ec = c; ea = a; end
      else if (m_rv) begin ec = m_rc; ea = m_ra; end
      if (f) begin m_rv = c[2]; m_rc = c; m_ra = a; end
    end
    if (s && wp) begin
      for (int k = 0; k < N; k++) begin
        if (ec == 4'd11 && ea == 4'(k)) m[k] = d[W-1:0];
        else if ((ec inside {4'd5, 4'd7, 4'd13, 4'd15}) ||
                 ((ec inside {4'd4, 4'd6, 4'd12, 4'd14}) && ea == 4'(k)))
          m[k] = step(ec, m[k]);
      end
    end
    for (int k = 0; k < N; k++) if (ld[k]) m[k] = lv[k*W +: W];
  endtask

  task automatic op(input logic s, input logic f, input logic [3:0] c,
                    input logic [3:0] a, input logic [7:0] d, input logic wp,
                    input logic [N-1:0] ld, input logic [N*W-1:0] lv, input string tag);
    item_t it;
    @(negedge clk);
    strobe = s; fresh = f; cmd = c; addr = a; data = d; wp_n = wp;
    nv_load = ld; nv_val = lv;
    model(s, f, c, a, d, wp, ld, lv);
    @(negedge clk);
    strobe = 0; fresh = 0; nv_load = 0; wp_n = 1;
    it.exp = pack(); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic cmdw(input logic [3:0] c, input logic [3:0] a, input logic [7:0] d, input string tag);
    op(1, 1, c, a, d, 1, '0, '0, tag);
  endtask

  task automatic bare(input string tag);
    op(1, 0, 4'd0, 4'd0, 8'h00, 1, '0, '0, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (wiper !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, wiper, it.exp);
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < N; k++) m[k] = 6'h20;
    repeat (3) @(negedge clk);
    rst_n = 1;
    op(0, 0, 0, 0, 0, 1, '0, '0, "R1 reset midscale");
    bare("R1 no remembered command after reset");
    cmdw(4'd11, 4'd1, 8'hFF, "R2 write uses low bits");
    cmdw(4'd11, 4'd2, 8'h05, "R2 write ch2");
    cmdw(4'd14, 4'd1, 8'h00, "R3 increment saturates at ones");
    cmdw(4'd6, 4'd2, 8'hA5, "R3 R7 decrement ignores data");
    for (int k = 0; k < 6; k++) bare("R8 R3 repeat decrement to zero");
    cmdw(4'd11, 4'd0, 8'h00, "R2 write zero");
    cmdw(4'd7, 4'd9, 8'hFF, "R4 decrement all saturating");
    cmdw(4'd15, 4'd0, 8'h3C, "R4 R7 increment all");
    bare("R8 repeat increment all");
    cmdw(4'd11, 4'd3, 8'h04, "R2 write ch3");
    cmdw(4'd12, 4'd3, 8'hFF, "R5 R7 shift left fills one");
    bare("R8 repeat shift left");
    cmdw(4'd4, 4'd3, 8'h12, "R5 shift right fills zero");
    cmdw(4'd13, 4'd0, 8'h00, "R6 shift left all");
    cmdw(4'd5, 4'd2, 8'h00, "R6 shift right all");
    bare("R8 repeat shift right all");
    cmdw(4'd11, 4'd0, 8'h2A, "R2 write ch0");
    bare("R8 bare strobe after write does nothing");
    op(1, 1, 4'd11, 4'd0, 8'h01, 0, '0, '0, "R9 protected write ignored");
    op(1, 1, 4'd15, 4'd0, 8'h00, 0, '0, '0, "R9 protected increment all ignored");
    op(1, 0, 4'd0, 4'd0, 8'h00, 0, '0, '0, "R9 protected repeat ignored");
    op(1, 1, 4'd11, 4'd1, 8'h07, 0, 4'b0010, {6'd0, 6'd0, 6'h11, 6'd0}, "R9 R10 load while protected");
    op(1, 1, 4'd11, 4'd2, 8'h09, 1, 4'b0100, {6'd0, 6'h33, 6'd0, 6'd0}, "R10 load wins over write");
    op(0, 0, 4'd0, 4'd0, 8'h00, 1, 4'b1001, {6'h0A, 6'd0, 6'd0, 6'h3E}, "R10 load without strobe");
    cmdw(4'd11, 4'd7, 8'h15, "R11 write to absent channel");
    cmdw(4'd14, 4'd4, 8'h00, "R11 increment absent channel");
    cmdw(4'd0, 4'd0, 8'h3F, "R12 code 0 no change");
    cmdw(4'd9, 4'd1, 8'h3F, "R12 code 9 no change");
    cmdw(4'd10, 4'd2, 8'h3F, "R12 code 10 no change");
    cmdw(4'd3, 4'd3, 8'h3F, "R12 code 3 no change");
    cmdw(4'd8, 4'd0, 8'h3F, "R12 code 8 no change");
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule